// File: doc/BRIEF.md
# Speculative Store Forwarding Cache

This block is a small set-associative side store. During speculative execution it passes the results of stores that have already left the instruction window on to later loads. Each entry is a line of bytes. For every byte the block keeps the data, a written flag and a poison flag. Because of the written flag, a load hits only on bytes that some speculative store actually produced. Because of the poison flag, a store whose data was bogus makes every load that reads those bytes bogus too.

Stores arrive on a write port. Each store carries a line address, a lane mask, data, a data-good flag and an address-good flag. Loads use a lookup port with a line address and a lane mask, and they get back a hit flag, a poison flag and the forwarded bytes one cycle later. When a line is evicted it is simply lost, because nothing behind this block holds speculative data. A flush input clears all line valid flags and all written flags in one cycle. It is used when speculation ends.

With the default parameters the block holds 512 bytes as 16 sets of 4 ways with 8-byte lines. The line address is split into a set index (its low 4 bits) and a tag (the remaining upper bits). Bit i of a lane mask selects byte i of the line, which is bits 8i+7 to 8i of the data buses.

Top module: `spec_fwd_cache`

## Requirements
- R1: After reset every lookup misses. It returns hit 0, poison 0 and data 0, and no response is valid until a load is issued.
- R2: A load sampled on a rising edge produces ld_resp_valid together with its hit, poison and data results right after the next rising edge. Cycles without a load produce no response.
- R3: A load hits only if the line of its set with a matching tag is valid and at least one byte selected by ld_mask has its written flag set. Selected bytes that were never written give a miss.
- R4: A store with st_data_ok 1 and st_addr_ok 1 writes its masked bytes, sets their written flags and clears their poison flags.
- R5: A store with st_data_ok 0 and st_addr_ok 1 sets both the poison and the written flags of its masked bytes. A hitting load that selects any poisoned byte returns poison 1 and data 0.
- R6: A store with st_addr_ok 0 changes nothing: no data, no flags, no allocation and no replacement state.
- R7: Flush clears every line valid flag and every written flag. A store presented in the flush cycle is dropped, and every later load misses until new stores arrive.
- R8: A store that misses its set allocates the lowest-numbered invalid way. If every way is valid, it allocates the way chosen by a tree pseudo-LRU, and the old contents of that way are discarded.
- R9: A newly allocated line starts with all written and poison flags clear, so only the bytes of the allocating store count as written.
- R10: A clean hit returns the stored byte in each lane that is both selected and written, and zero in every other lane.
- R11: A load and a store to the same line in the same cycle: the load sees the contents before the store.
- R12: Every accepted store updates the pseudo-LRU state of its set, whether it hit or allocated, so that the touched way is not the next victim. Loads never change replacement state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all lines and written flags |
| st_valid | input | 1 | Store request present |
| st_line | input | LADDR_W (13) | Store line address: tag above the set index |
| st_mask | input | LINE_BYTES (8) | Store lane mask |
| st_data | input | LINE_BYTES*8 (64) | Store data, lane-aligned |
| st_data_ok | input | 1 | Store data is valid (0 means poison) |
| st_addr_ok | input | 1 | Store address is valid (0 means no-op) |
| ld_valid | input | 1 | Load lookup present |
| ld_line | input | LADDR_W (13) | Load line address |
| ld_mask | input | LINE_BYTES (8) | Load lane mask |
| ld_resp_valid | output | 1 | Load result valid |
| ld_hit | output | 1 | Load hit |
| ld_poison | output | 1 | Load result is poisoned |
| ld_data | output | LINE_BYTES*8 (64) | Forwarded bytes, zero in unselected or unwritten lanes |

## Verification
Each load result comes out one cycle after the load is issued. Flag and data state written by a store can be seen by a load issued in the cycle after that store, but not by a load issued in the same cycle. The driver changes inputs only on falling edges and pushes the expected result of each load into a queue as it issues the load. The monitor pops one entry on each falling edge where a response is flagged, which is exactly one cycle after the load was issued. It reports a response that arrives with nothing expected, and at the end it reports any expected response that never arrived. The eviction, flush and replacement checks issue their loads in the cycle after the stores they probe, except for the same-cycle collision check, which deliberately issues both together.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned SFC_LADDR_W    = 13;
  localparam int unsigned SFC_LINE_BYTES = 8;
  localparam int unsigned SFC_WAYS       = 4;
  localparam int unsigned SFC_CAP_BYTES  = 512;

  // index of the lowest set bit, 0 when none
  function automatic int unsigned first_one(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/sfc_way_data.sv
module sfc_way_data #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned LB    = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [LB-1:0]     wbe,
  input  logic [LB*8-1:0]   wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [LB*8-1:0]   rdata
);
  logic [LB*8-1:0] mem [SETS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < int'(LB); b++) begin
        if (wbe[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  // read-before-write: same-edge store is not visible
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfc_way_meta.sv
module sfc_way_meta #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned LB    = 8,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [IDX_W-1:0]  st_idx,
  output logic              st_vld,
  output logic [TAG_W-1:0]  st_tag,
  input  logic [IDX_W-1:0]  ld_idx,
  output logic              ld_vld,
  output logic [TAG_W-1:0]  ld_tag,
  output logic [LB-1:0]     ld_sto,
  output logic [LB-1:0]     ld_inv,
  input  logic              wr_en,
  input  logic              wr_alloc,
  input  logic              wr_data_ok,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LB-1:0]     wr_mask
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [LB-1:0]    sto_q [SETS];
  logic [LB-1:0]    inv_q [SETS];

  assign st_vld = vld_q[st_idx];
  assign st_tag = tag_q[st_idx];
  assign ld_vld = vld_q[ld_idx];
  assign ld_tag = tag_q[ld_idx];
  assign ld_sto = sto_q[ld_idx];
  assign ld_inv = inv_q[ld_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int s = 0; s < int'(SETS); s++) begin
        sto_q[s] <= '0;
        inv_q[s] <= '0;
        tag_q[s] <= '0;
      end
    end else if (flush) begin
      vld_q <= '0;
      for (int s = 0; s < int'(SETS); s++) sto_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[st_idx] <= 1'b1;
      tag_q[st_idx] <= wr_tag;
      if (wr_alloc) begin
        sto_q[st_idx] <= wr_mask;
        inv_q[st_idx] <= wr_data_ok ? '0 : wr_mask;
      end else begin
        sto_q[st_idx] <= sto_q[st_idx] | wr_mask;
        inv_q[st_idx] <= wr_data_ok ? (inv_q[st_idx] & ~wr_mask)
                                    : (inv_q[st_idx] | wr_mask);
      end
    end
  end

  // R4
  clean_store_clears_poison_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && wr_data_ok) |=> ((inv_q[$past(st_idx)] & $past(wr_mask)) == '0));

  // R9
  fresh_line_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && wr_alloc) |=> (sto_q[$past(st_idx)] == $past(wr_mask)));

  // R7
  flush_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));
endmodule

// File: rtl/sfc_plru.sv
module sfc_plru #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned WAY_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WAY_W-1:0]  victim,
  input  logic              touch_en,
  input  logic [IDX_W-1:0]  touch_idx,
  input  logic [WAY_W-1:0]  touch_way
);
  localparam int unsigned NODES = WAYS - 1;

  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] tree_cur, tree_nxt;

  // walk from the root: each node points at the colder half
  always_comb begin
    int node;
    node = 0;
    victim = '0;
    for (int lvl = 0; lvl < int'(WAY_W); lvl++) begin
      victim[WAY_W-1-lvl] = tree_q[rd_idx][node];
      node = 2*node + 1 + int'(tree_q[rd_idx][node]);
    end
  end

  // point every node on the touched path away from it
  always_comb begin
    int node;
    node = 0;
    tree_cur = tree_q[touch_idx];
    tree_nxt = tree_cur;
    for (int lvl = 0; lvl < int'(WAY_W); lvl++) begin
      tree_nxt[node] = ~touch_way[WAY_W-1-lvl];
      node = 2*node + 1 + int'(touch_way[WAY_W-1-lvl]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < int'(SETS); s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_idx] <= tree_nxt;
    end
  end

  // R12
  touched_not_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (touch_en ##1 (rd_idx == $past(touch_idx))) |-> (victim != $past(touch_way)));
endmodule

// File: rtl/spec_fwd_cache.sv
module spec_fwd_cache
  import sfc_pkg::*;
#(
  parameter int unsigned LADDR_W    = SFC_LADDR_W,
  parameter int unsigned LINE_BYTES = SFC_LINE_BYTES,
  parameter int unsigned WAYS       = SFC_WAYS,
  parameter int unsigned CAP_BYTES  = SFC_CAP_BYTES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      st_valid,
  input  logic [LADDR_W-1:0]        st_line,
  input  logic [LINE_BYTES-1:0]     st_mask,
  input  logic [LINE_BYTES*8-1:0]   st_data,
  input  logic                      st_data_ok,
  input  logic                      st_addr_ok,
  input  logic                      ld_valid,
  input  logic [LADDR_W-1:0]        ld_line,
  input  logic [LINE_BYTES-1:0]     ld_mask,
  output logic                      ld_resp_valid,
  output logic                      ld_hit,
  output logic                      ld_poison,
  output logic [LINE_BYTES*8-1:0]   ld_data
);
  localparam int unsigned LB    = LINE_BYTES;
  localparam int unsigned DW    = LB * 8;
  localparam int unsigned SETS  = CAP_BYTES / (WAYS * LB);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = LADDR_W - IDX_W;
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic [IDX_W-1:0] st_idx, ld_idx;
  logic [TAG_W-1:0] st_tag, ld_tag;
  assign st_idx = st_line[IDX_W-1:0];
  assign st_tag = st_line[LADDR_W-1:IDX_W];
  assign ld_idx = ld_line[IDX_W-1:0];
  assign ld_tag = ld_line[LADDR_W-1:IDX_W];

  logic [WAYS-1:0]  st_vld_w, ld_vld_w, way_wr_en;
  logic [TAG_W-1:0] st_tag_w [WAYS];
  logic [TAG_W-1:0] ld_tag_w [WAYS];
  logic [LB-1:0]    ld_sto_w [WAYS];
  logic [LB-1:0]    ld_inv_w [WAYS];
  logic [DW-1:0]    rdata_w  [WAYS];

  logic             st_go, st_hit, any_free;
  logic [WAYS-1:0]  st_match, ld_match, free_vec;
  logic [WAY_W-1:0] hit_way, free_way, plru_way, tgt_way, ld_way;

  // store path: hit, free-way and victim choice
  always_comb begin
    for (int w = 0; w < int'(WAYS); w++) begin
      st_match[w] = st_vld_w[w] && (st_tag_w[w] == st_tag);
    end
  end

  assign free_vec = ~st_vld_w;
  assign st_hit   = |st_match;
  assign any_free = |free_vec;
  assign hit_way  = WAY_W'(first_one(32'(st_match)));
  assign free_way = WAY_W'(first_one(32'(free_vec)));
  assign tgt_way  = st_hit ? hit_way : (any_free ? free_way : plru_way);
  assign st_go    = st_valid && st_addr_ok && !flush;

  always_comb begin
    for (int w = 0; w < int'(WAYS); w++) begin
      way_wr_en[w] = st_go && (tgt_way == WAY_W'(w));
    end
  end

  generate
    for (genvar g = 0; g < int'(WAYS); g++) begin : g_way
      sfc_way_meta #(.SETS(SETS), .LB(LB), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_meta (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .st_idx     (st_idx),
        .st_vld     (st_vld_w[g]),
        .st_tag     (st_tag_w[g]),
        .ld_idx     (ld_idx),
        .ld_vld     (ld_vld_w[g]),
        .ld_tag     (ld_tag_w[g]),
        .ld_sto     (ld_sto_w[g]),
        .ld_inv     (ld_inv_w[g]),
        .wr_en      (way_wr_en[g]),
        .wr_alloc   (!st_hit),
        .wr_data_ok (st_data_ok),
        .wr_tag     (st_tag),
        .wr_mask    (st_mask)
      );

      sfc_way_data #(.SETS(SETS), .LB(LB), .IDX_W(IDX_W)) u_data (
        .clk   (clk),
        .we    (way_wr_en[g] && st_data_ok),
        .waddr (st_idx),
        .wbe   (st_mask),
        .wdata (st_data),
        .raddr (ld_idx),
        .rdata (rdata_w[g])
      );
    end
  endgenerate

  sfc_plru #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_plru (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (st_idx),
    .victim    (plru_way),
    .touch_en  (st_go),
    .touch_idx (st_idx),
    .touch_way (tgt_way)
  );

  // load path: lookup on pre-edge state, results registered
  logic          ld_hit_c, ld_poison_c;
  logic [LB-1:0] ld_sel_c;

  always_comb begin
    for (int w = 0; w < int'(WAYS); w++) begin
      ld_match[w] = ld_vld_w[w] && (ld_tag_w[w] == ld_tag) && |(ld_mask & ld_sto_w[w]);
    end
  end

  assign ld_way      = WAY_W'(first_one(32'(ld_match)));
  assign ld_hit_c    = |ld_match;
  assign ld_poison_c = ld_hit_c && |(ld_mask & ld_sto_w[ld_way] & ld_inv_w[ld_way]);
  assign ld_sel_c    = (ld_hit_c && !ld_poison_c) ? (ld_mask & ld_sto_w[ld_way]) : '0;

  logic             resp_q, hit_q, poison_q;
  logic [LB-1:0]    sel_q;
  logic [WAY_W-1:0] way_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q   <= 1'b0;
      hit_q    <= 1'b0;
      poison_q <= 1'b0;
      sel_q    <= '0;
      way_q    <= '0;
    end else begin
      resp_q   <= ld_valid;
      hit_q    <= ld_valid && ld_hit_c;
      poison_q <= ld_valid && ld_poison_c;
      sel_q    <= ld_valid ? ld_sel_c : '0;
      way_q    <= ld_way;
    end
  end

  assign ld_resp_valid = resp_q;
  assign ld_hit        = hit_q;
  assign ld_poison     = poison_q;

  always_comb begin
    for (int b = 0; b < int'(LB); b++) begin
      ld_data[b*8 +: 8] = sel_q[b] ? rdata_w[way_q][b*8 +: 8] : 8'h00;
    end
  end

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> ld_resp_valid);

  // R5
  poison_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ld_poison |-> (ld_hit && ld_data == '0));

  // R6
  bad_addr_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_addr_ok) |-> (way_wr_en == '0));

  // R8
  single_way_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_wr_en));

  // R8
  free_way_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st_go && !st_hit && any_free) |-> ((way_wr_en & ~free_vec) == '0));

  // R7
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (flush ##1 ld_valid) |=> !ld_hit);
endmodule

// File: tb/spec_fwd_cache_bench.sv
module spec_fwd_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        st_valid = 1'b0;
  logic [12:0] st_line = '0;
  logic [7:0]  st_mask = '0;
  logic [63:0] st_data = '0;
  logic        st_data_ok = 1'b0;
  logic        st_addr_ok = 1'b0;
  logic        ld_valid = 1'b0;
  logic [12:0] ld_line = '0;
  logic [7:0]  ld_mask = '0;
  logic        ld_resp_valid, ld_hit, ld_poison;
  logic [63:0] ld_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        hit;
    logic        poison;
    logic [63:0] data;
    string       req;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_fwd_cache u_spec_fwd_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .st_valid(st_valid), .st_line(st_line), .st_mask(st_mask), .st_data(st_data),
    .st_data_ok(st_data_ok), .st_addr_ok(st_addr_ok),
    .ld_valid(ld_valid), .ld_line(ld_line), .ld_mask(ld_mask),
    .ld_resp_valid(ld_resp_valid), .ld_hit(ld_hit), .ld_poison(ld_poison), .ld_data(ld_data)
  );

  function automatic logic [12:0] mk(input int tag, input int idx);
    return {9'(tag), 4'(idx)};
  endfunction

  // one cycle of stimulus; loads queue their expected result
  task automatic drive(input logic sv, input logic [12:0] sl, input logic [7:0] sm,
                       input logic [63:0] sd, input logic sdok, input logic saok,
                       input logic lv, input logic [12:0] ll, input logic [7:0] lm,
                       input logic eh, input logic ep, input logic [63:0] ed,
                       input string req, input logic fl);
    exp_t e;
    @(negedge clk);
    st_valid = sv; st_line = sl; st_mask = sm; st_data = sd;
    st_data_ok = sdok; st_addr_ok = saok;
    ld_valid = lv; ld_line = ll; ld_mask = lm; flush = fl;
    if (lv) begin
      e.hit = eh; e.poison = ep; e.data = ed; e.req = req;
      expq.push_back(e);
    end
  endtask

  task automatic st(input logic [12:0] a, input logic [7:0] m, input logic [63:0] d,
                    input logic dok, input logic aok);
    drive(1, a, m, d, dok, aok, 0, '0, '0, 0, 0, '0, "", 0);
  endtask

  task automatic ld(input logic [12:0] a, input logic [7:0] m, input logic eh,
                    input logic ep, input logic [63:0] ed, input string req);
    drive(0, '0, '0, '0, 0, 0, 1, a, m, eh, ep, ed, req, 0);
  endtask

  task automatic idle();
    drive(0, '0, '0, '0, 0, 0, 0, '0, '0, 0, 0, '0, "", 0);
  endtask

  // monitor: a response is due one cycle after its load
  always @(negedge clk) begin
    if (!rst && ld_resp_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected response actual hit=%0b expected none", ld_hit);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (ld_hit !== e.hit || ld_poison !== e.poison || ld_data !== e.data) begin
          errors++;
          $display("FAIL %s: actual hit=%0b poison=%0b data=%h expected hit=%0b poison=%0b data=%h",
                   e.req, ld_hit, ld_poison, ld_data, e.hit, e.poison, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (ld_resp_valid !== 1'b0 || ld_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual resp=%0b hit=%0b expected 0 0", ld_resp_valid, ld_hit);
    end
    ld(mk(1,2), 8'hFF, 0, 0, 64'h0, "R1");

    // R4 / R10 clean store then load
    st(mk(1,2), 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD, 1, 1);
    ld(mk(1,2), 8'h0F, 1, 0, 64'h0000_0000_CCCC_DDDD, "R4");
    ld(mk(1,2), 8'hF0, 0, 0, 64'h0, "R3");
    ld(mk(1,2), 8'h3C, 1, 0, 64'h0000_0000_CCCC_0000, "R10");

    // R5 poisoned store
    st(mk(1,2), 8'h10, 64'h0, 0, 1);
    ld(mk(1,2), 8'h30, 1, 1, 64'h0, "R5");
    ld(mk(1,2), 8'h01, 1, 0, 64'h0000_0000_0000_00DD, "R5");

    // R4 clean store clears poison
    st(mk(1,2), 8'h10, 64'h0000_005A_0000_0000, 1, 1);
    ld(mk(1,2), 8'h10, 1, 0, 64'h0000_005A_0000_0000, "R4");

    // R6 address-invalid stores
    st(mk(3,5), 8'hFF, 64'h1234_5678_9ABC_DEF0, 1, 0);
    ld(mk(3,5), 8'hFF, 0, 0, 64'h0, "R6");
    st(mk(1,2), 8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
    ld(mk(1,2), 8'h0F, 1, 0, 64'h0000_0000_CCCC_DDDD, "R6");

    // R11 same-cycle store and load
    drive(1, mk(1,2), 8'h0F, 64'h0000_0000_0102_0304, 1, 1,
          1, mk(1,2), 8'h0F, 1, 0, 64'h0000_0000_CCCC_DDDD, "R11", 0);
    ld(mk(1,2), 8'h0F, 1, 0, 64'h0000_0000_0102_0304, "R11");

    // R7 flush, store in same cycle dropped
    drive(1, mk(2,2), 8'hFF, 64'h1, 1, 1, 0, '0, '0, 0, 0, '0, "", 1);
    ld(mk(1,2), 8'hFF, 0, 0, 64'h0, "R7");
    ld(mk(2,2), 8'hFF, 0, 0, 64'h0, "R7");

    // R8 / R9 / R12 replacement in set 7
    st(mk(10,7), 8'hFF, {8{8'hA0}}, 1, 1);
    st(mk(11,7), 8'h01, {8{8'hA1}}, 1, 1);
    st(mk(12,7), 8'h01, {8{8'hA2}}, 1, 1);
    st(mk(13,7), 8'h01, {8{8'hA3}}, 1, 1);
    st(mk(14,7), 8'h01, {8{8'hA4}}, 1, 1);
    ld(mk(10,7), 8'hFF, 0, 0, 64'h0, "R8");
    ld(mk(14,7), 8'h02, 0, 0, 64'h0, "R9");
    ld(mk(14,7), 8'h01, 1, 0, 64'hA4, "R8");
    ld(mk(11,7), 8'h01, 1, 0, 64'hA1, "R8");
    st(mk(11,7), 8'h02, {8{8'hA1}}, 1, 1);
    st(mk(15,7), 8'h01, {8{8'hA5}}, 1, 1);
    ld(mk(12,7), 8'h01, 0, 0, 64'h0, "R12");
    ld(mk(13,7), 8'h01, 1, 0, 64'hA3, "R8");
    ld(mk(15,7), 8'h01, 1, 0, 64'hA5, "R8");
    ld(mk(11,7), 8'h03, 1, 0, 64'hA1A1, "R12");
    // loads must not refresh the way holding tag 14
    ld(mk(14,7), 8'h01, 1, 0, 64'hA4, "R12");
    ld(mk(14,7), 8'h01, 1, 0, 64'hA4, "R12");
    st(mk(16,7), 8'h01, {8{8'hA6}}, 1, 1);
    ld(mk(14,7), 8'h01, 0, 0, 64'h0, "R12");
    ld(mk(13,7), 8'h01, 1, 0, 64'hA3, "R12");
    ld(mk(16,7), 8'h01, 1, 0, 64'hA6, "R12");

    idle();
    idle();
    idle();
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d responses missing expected 0", expq.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule